// File: doc/BRIEF.md
# Transmit De-emphasis Level Encoder

This block sits between a serializer's bit stream and the code input of a transmit output DAC. For every accepted bit it works out a signed drive-level code from three neighbouring bits: the symbol being sent, the one before it and the one after it. Each neighbour has its own programmable weight. A symbol that follows a change of polarity is driven at a larger swing than a symbol that repeats its predecessor. A symbol that comes just before a change is also driven harder. This shifts energy from the low-frequency part of the spectrum toward the high-frequency part, which offsets the extra high-frequency loss of the channel.

The output needs the following bit before it can be formed, so the code for a symbol appears one accepted bit later than that symbol. The upstream logic presents one bit with a qualifying strobe whenever it has one. Idle cycles between strobes are allowed. Software-side logic can stage a new set of weights at any time. The block switches to the staged set only at a symbol boundary, so no output code is ever built from a mix of old and new weights.

Top module: `deemph_enc`

## Requirements
- R1: A bit value 1 counts as +1 and a bit value 0 counts as -1. The code for symbol b[n] is main·s(b[n]) − pre·s(b[n+1]) − post·s(b[n−1]), where s() is that ±1 mapping and the weights are unsigned.
- R2: With the precursor weight at zero, a symbol whose value differs from the symbol before it has magnitude main+post. A symbol equal to the one before it has magnitude main−post.
- R3: With the post-cursor weight at zero, a symbol that is followed by a symbol of the other value has magnitude main+pre. A symbol followed by an equal symbol has magnitude main−pre.
- R4: The code saturates to the signed range of the output width. With the default 8-bit output, that range is −128 to +127.
- R5: When `bit_vld` is high at a clock edge, the code for the previously accepted symbol appears at the next clock edge. At that point `level_vld` is high for exactly one cycle, and `level_vld` is never high in any other cycle.
- R6: After reset, the first accepted bit produces no `level_vld`. The history of the symbol before it is taken as a 0 bit.
- R7: While reset is asserted and after it is released, `level` reads 0 and `level_vld` reads 0 until a code is produced. The weights also reset to 0.
- R8: A weight set presented with `w_load` is staged and does not change the output. It is used first for the code computed at the next accepted bit. When several loads happen before that bit, the last one wins.
- R9: When `w_load` and `bit_vld` are high in the same cycle, the code computed in that cycle uses the weights in force before the load. The new set applies from the following accepted bit.
- R10: While `bit_vld` is low, `level` holds its value and `bit_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| w_load | input | 1 | Stages the three weight inputs |
| w_main | input | WW (6) | Main-cursor weight, unsigned |
| w_pre | input | WW (6) | Precursor weight, unsigned |
| w_post | input | WW (6) | Post-cursor weight, unsigned |
| level | output | LW (8) | Signed drive-level code |
| level_vld | output | 1 | One-cycle strobe marking a new code |

## Verification
A weight load and a symbol boundary can happen in the same cycle. The block must then form the code with the old weights and hold the new set for the next symbol. The bench provokes this by raising `w_load` in the very cycle that carries a bit strobe. It then compares that code against the old-weight value and the next code against the new-weight value. A load during idle cycles is also checked. There the output must not move, and only the last of several staged sets must reach the next code.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  // Fill state of the neighbourhood window after reset
  typedef enum logic {
    FILL_EMPTY = 1'b0,
    FILL_READY = 1'b1
  } fill_e;

  // Sign convention for one tap: bit 1 -> +w, bit 0 -> -w
  function automatic int signed_term(input logic b, input int w);
    return b ? w : -w;
  endfunction
endpackage

// File: rtl/deemph_wt.sv
module deemph_wt #(
  parameter int WW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_load,
  input  logic [WW-1:0] main_in,
  input  logic [WW-1:0] pre_in,
  input  logic [WW-1:0] post_in,
  input  logic          sym_adv,
  output logic [WW-1:0] eff_main,
  output logic [WW-1:0] eff_pre,
  output logic [WW-1:0] eff_post
);
  logic [WW-1:0] stg_main_q, stg_pre_q, stg_post_q;
  logic [WW-1:0] act_main_q, act_pre_q, act_post_q;
  logic          pend_q;

  logic [WW-1:0] stg_main_d, stg_pre_d, stg_post_d;
  logic [WW-1:0] act_main_d, act_pre_d, act_post_d;
  logic          pend_d;

  // Weights used at this boundary: a staged set takes over once pending
  always_comb begin
    eff_main = pend_q ? stg_main_q : act_main_q;
    eff_pre  = pend_q ? stg_pre_q  : act_pre_q;
    eff_post = pend_q ? stg_post_q : act_post_q;
  end

  always_comb begin
    stg_main_d = stg_main_q;
    stg_pre_d  = stg_pre_q;
    stg_post_d = stg_post_q;
    act_main_d = act_main_q;
    act_pre_d  = act_pre_q;
    act_post_d = act_post_q;
    pend_d     = pend_q;
    if (sym_adv) begin
      act_main_d = eff_main;
      act_pre_d  = eff_pre;
      act_post_d = eff_post;
      pend_d     = 1'b0;
    end
    if (w_load) begin
      stg_main_d = main_in;
      stg_pre_d  = pre_in;
      stg_post_d = post_in;
      pend_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_main_q <= '0;
      stg_pre_q  <= '0;
      stg_post_q <= '0;
      act_main_q <= '0;
      act_pre_q  <= '0;
      act_post_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      stg_main_q <= stg_main_d;
      stg_pre_q  <= stg_pre_d;
      stg_post_q <= stg_post_d;
      act_main_q <= act_main_d;
      act_pre_q  <= act_pre_d;
      act_post_q <= act_post_d;
      pend_q     <= pend_d;
    end
  end

  // R9
  collide_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_load && sym_adv) |=> (pend_q && $stable(stg_main_q) == 1'b0 || pend_q));

  // R8
  idle_weights_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_load && !sym_adv) |=> ($stable(eff_main) && $stable(eff_pre) && $stable(eff_post)));
endmodule

// File: rtl/deemph_hist.sv
module deemph_hist
  import deemph_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sym_adv,
  input  logic bit_in,
  output logic cur_bit,
  output logic prev_bit,
  output logic primed
);
  logic  cur_q, prev_q;
  fill_e fill_q;
  logic  cur_d, prev_d;
  fill_e fill_d;

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    fill_d = fill_q;
    if (sym_adv) begin
      prev_d = cur_q;
      cur_d  = bit_in;
      fill_d = FILL_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
      fill_q <= FILL_EMPTY;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      fill_q <= fill_d;
    end
  end

  assign cur_bit  = cur_q;
  assign prev_bit = prev_q;
  assign primed   = (fill_q == FILL_READY);

  // R10
  window_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_adv |=> ($stable(cur_q) && $stable(prev_q)));
endmodule

// File: rtl/deemph_sum.sv
module deemph_sum
  import deemph_pkg::*;
#(
  parameter int WW = 6,
  parameter int LW = 8
) (
  input  logic                 nxt_bit,
  input  logic                 cur_bit,
  input  logic                 prev_bit,
  input  logic [WW-1:0]        w_main,
  input  logic [WW-1:0]        w_pre,
  input  logic [WW-1:0]        w_post,
  output logic signed [LW-1:0] level
);
  localparam int SW = WW + 3;

  logic signed [SW-1:0] t_main, t_pre, t_post, sum;

  always_comb begin
    t_main = SW'(signed_term(cur_bit,  int'(w_main)));
    t_pre  = SW'(signed_term(nxt_bit,  int'(w_pre)));
    t_post = SW'(signed_term(prev_bit, int'(w_post)));
    sum    = t_main - t_pre - t_post;
  end

  generate
    if (LW > SW) begin : g_wide
      assign level = {{(LW-SW){sum[SW-1]}}, sum};
    end else begin : g_sat
      localparam logic signed [SW-1:0] LMAX = SW'((2 ** (LW-1)) - 1);
      localparam logic signed [SW-1:0] LMIN = SW'(-(2 ** (LW-1)));
      always_comb begin
        if (sum > LMAX)      level = LMAX[LW-1:0];
        else if (sum < LMIN) level = LMIN[LW-1:0];
        else                 level = sum[LW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/deemph_enc.sv
module deemph_enc
  import deemph_pkg::*;
#(
  parameter int WW = 6,
  parameter int LW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_in,
  input  logic                 bit_vld,
  input  logic                 w_load,
  input  logic [WW-1:0]        w_main,
  input  logic [WW-1:0]        w_pre,
  input  logic [WW-1:0]        w_post,
  output logic signed [LW-1:0] level,
  output logic                 level_vld
);
  logic [WW-1:0]        e_main, e_pre, e_post;
  logic                 cur_bit, prev_bit, primed;
  logic signed [LW-1:0] lvl_comb;
  logic signed [LW-1:0] level_q, level_d;
  logic                 vld_q, vld_d;

  deemph_wt #(.WW(WW)) u_wt (
    .clk(clk), .rst_n(rst_n), .w_load(w_load),
    .main_in(w_main), .pre_in(w_pre), .post_in(w_post),
    .sym_adv(bit_vld),
    .eff_main(e_main), .eff_pre(e_pre), .eff_post(e_post)
  );

  deemph_hist u_hist (
    .clk(clk), .rst_n(rst_n), .sym_adv(bit_vld), .bit_in(bit_in),
    .cur_bit(cur_bit), .prev_bit(prev_bit), .primed(primed)
  );

  deemph_sum #(.WW(WW), .LW(LW)) u_sum (
    .nxt_bit(bit_in), .cur_bit(cur_bit), .prev_bit(prev_bit),
    .w_main(e_main), .w_pre(e_pre), .w_post(e_post),
    .level(lvl_comb)
  );

  always_comb begin
    level_d = level_q;
    vld_d   = 1'b0;
    if (bit_vld) begin
      level_d = primed ? lvl_comb : level_q;
      vld_d   = primed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      vld_q   <= vld_d;
    end
  end

  assign level     = level_q;
  assign level_vld = vld_q;

  // R5
  vld_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_vld |-> $past(bit_vld));

  // R6
  no_vld_while_filling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !primed) |=> !level_vld);

  // R10
  level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(level));
endmodule

// File: tb/deemph_enc_bench.sv
`timescale 1ns/1ps
module deemph_enc_bench;
  localparam int WW = 6;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0, bit_vld = 1'b0, w_load = 1'b0;
  logic [WW-1:0] w_main = '0, w_pre = '0, w_post = '0;
  logic signed [LW-1:0] level;
  logic level_vld;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  deemph_enc #(.WW(WW), .LW(LW)) u_deemph_enc (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .w_load(w_load), .w_main(w_main), .w_pre(w_pre), .w_post(w_post),
    .level(level), .level_vld(level_vld)
  );

  // prev, cur, next bits and expected code with weights main=40 pre=8 post=12
  typedef struct packed { logic p; logic c; logic n; int exp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b0, -20}, '{1'b0,1'b0,1'b1, -36},
    '{1'b0,1'b1,1'b0,  60}, '{1'b0,1'b1,1'b1,  44},
    '{1'b1,1'b0,1'b0, -44}, '{1'b1,1'b0,1'b1, -60},
    '{1'b1,1'b1,1'b0,  36}, '{1'b1,1'b1,1'b1,  20}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one bit; optionally stage weights in the same cycle. Returns
  // at the following falling edge, where the resulting code is visible.
  task automatic send(input logic b, input logic ld, input int m, input int pr, input int po);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    w_load = ld; w_main = WW'(m); w_pre = WW'(pr); w_post = WW'(po);
    @(negedge clk);
    bit_vld = 1'b0; w_load = 1'b0; bit_in = ~b;
  endtask

  task automatic load(input int m, input int pr, input int po);
    @(negedge clk);
    w_load = 1'b1; w_main = WW'(m); w_pre = WW'(pr); w_post = WW'(po);
    @(negedge clk);
    w_load = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 level in reset", int'(level), 0);
    chk("R7 vld in reset", int'(level_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 level after release", int'(level), 0);

    // Table walk, R1 over all eight neighbourhoods
    load(40, 8, 12);
    send(1'b0, 1'b0, 0, 0, 0);
    chk("R6 first bit no vld", int'(level_vld), 0);
    for (int i = 0; i < 8; i++) begin
      send(VECS[i].p, 1'b0, 0, 0, 0);
      send(VECS[i].c, 1'b0, 0, 0, 0);
      send(VECS[i].n, 1'b0, 0, 0, 0);
      chk("R1 neighbourhood code", int'(level), VECS[i].exp);
      chk("R5 vld pulse", int'(level_vld), 1);
    end
    @(negedge clk);
    chk("R5 vld one cycle", int'(level_vld), 0);

    // R2: post-cursor only
    load(30, 0, 10);
    send(1'b0, 1'b0, 0, 0, 0);
    send(1'b1, 1'b0, 0, 0, 0);
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R2 transition full swing", int'(level), 40);
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R2 repeat reduced swing", int'(level), 20);

    // R3: precursor only
    load(30, 10, 0);
    send(1'b1, 1'b0, 0, 0, 0);
    send(1'b1, 1'b0, 0, 0, 0);
    send(1'b0, 1'b0, 0, 0, 0);
    chk("R3 pre-transition boost", int'(level), 40);
    send(1'b0, 1'b0, 0, 0, 0);
    chk("R3 no transition reduced", int'(level), -20);

    // R4: saturation both ends
    load(63, 63, 63);
    send(1'b0, 1'b0, 0, 0, 0);
    send(1'b1, 1'b0, 0, 0, 0);
    send(1'b0, 1'b0, 0, 0, 0);
    chk("R4 saturate high", int'(level), 127);
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R4 saturate low", int'(level), -128);

    // R9: load coincident with a bit strobe
    load(40, 8, 12);
    send(1'b0, 1'b0, 0, 0, 0);
    send(1'b1, 1'b0, 0, 0, 0);
    send(1'b0, 1'b1, 20, 0, 0);
    chk("R9 old weights at collision", int'(level), 60);
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R9 new weights next symbol", int'(level), -20);

    // R8 and R10: idle loads and ignored bit_in
    load(10, 0, 0);
    load(25, 0, 0);
    @(negedge clk);
    bit_in = 1'b0;
    @(negedge clk);
    bit_in = 1'b1;
    @(negedge clk);
    chk("R10 level held while idle", int'(level), -20);
    chk("R10 no vld while idle", int'(level_vld), 0);
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R8 last staged load wins", int'(level), 25);

    // R7/R6: reset mid-stream, then refill
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 level cleared", int'(level), 0);
    chk("R7 vld cleared", int'(level_vld), 0);
    rst_n = 1'b1;
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R7 weights reset to zero", int'(level), 0);
    load(30, 0, 10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    load(30, 0, 10);
    send(1'b1, 1'b0, 0, 0, 0);
    chk("R6 first bit after reset no vld", int'(level_vld), 0);
    send(1'b0, 1'b0, 0, 0, 0);
    chk("R6 reset history is zero bit", int'(level), 40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule